// File: doc/BRIEF.md
# Power-Management Command Port with Gated SMI Request

This block sits behind a byte-wide power-management command port. Every byte software writes to the port is decoded. Two reserved codes switch the platform between legacy mode and ACPI mode by setting or clearing a single mode flag, `sci_en`. Every other code is forwarded as a system-management interrupt request. That request is issued only when a gate bit in a small bank of configuration bytes allows it.

The configuration bank holds four bytes at consecutive configuration offsets, 0x58 through 0x5B. Bit 1 of the byte at offset 0x5B is the SMI gate. Reset clears all four bytes. The exception is when the `smm_strap` input is low, meaning the platform has no SMM support: in that case the byte at 0x5B takes the value 0x02, which marks SMM as already set up. The SMI request leaves the block as a one-cycle pulse for each qualifying write. The last byte written to the command port can be read back.

Top module: `apm_smi_ctrl`

## Requirements
- R1: With `smm_strap` high, reset gives `sci_en`=0, `smi_pulse`=0, `ctl_rd_data`=0x00, and all four configuration bytes at 0x58..0x5B read as 0x00.
- R2: With `smm_strap` low, reset loads 0x02 into the byte at offset 0x5B and 0x00 into the other three. A later non-command write to the command port then raises an SMI pulse.
- R3: A command-port write of 0xF1 sets `sci_en` to 1 in the cycle after the write.
- R4: A command-port write of 0xF0 clears `sci_en` to 0 in the cycle after the write.
- R5: A write of 0xF0 or 0xF1 never produces an SMI pulse, whatever the gate bit holds.
- R6: A write of any other value makes `smi_pulse` 1 in the cycle after the write if bit 1 of configuration byte 0x5B is set. If that bit is clear, `smi_pulse` stays 0.
- R7: `smi_pulse` is high for exactly one cycle per qualifying write. Back-to-back qualifying writes give one pulse each, on consecutive cycles.
- R8: When a command-port write and a configuration write happen in the same cycle, the SMI decision uses the gate bit as it was before that configuration write.
- R9: `sci_en` changes only in response to the two command codes. Other command-port writes and configuration writes leave it unchanged.
- R10: `ctl_rd_data` returns the last byte written to the command port, command codes included, from the cycle after the write.
- R11: A configuration write to 0x58..0x5B updates that byte, and `cfg_rd_data` returns the addressed byte one cycle after `cfg_addr` is presented. Addresses outside the window read 0x00 and writes to them change nothing. Only bit 1 of 0x5B gates the SMI; its other bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smm_strap | input | 1 | High when the platform supports SMM; selects the reset value of byte 0x5B |
| ctl_wr_en | input | 1 | Command-port write strobe |
| ctl_wr_data | input | 8 | Command-port write byte |
| ctl_rd_data | output | 8 | Last byte written to the command port |
| cfg_wr_en | input | 1 | Configuration-byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset, for both reads and writes |
| cfg_wr_data | input | 8 | Configuration write byte |
| cfg_rd_data | output | 8 | Addressed configuration byte, registered |
| smi_pulse | output | 1 | One-cycle SMI request |
| sci_en | output | 1 | ACPI mode flag |

## Verification
The command port is driven with the two mode codes and with ordinary codes, each under both gate settings. This separates a mode switch from an SMI request and shows that the gate matters only for ordinary codes. Back-to-back ordinary writes check that pulses neither merge nor stretch. Writes issued in the same cycle as a gate change, in both directions, show whether the decision uses the old gate value or the new one. A gate byte with every bit set except bit 1 checks that only that bit is decoded. Resets taken with the strap high and then low compare the two reset values of byte 0x5B.

// File: rtl/apm_smi_pkg.sv
`timescale 1ns/1ps
package apm_smi_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ACPI_ON_CODE  = 8'hF1;
  localparam logic [BYTE_W-1:0] ACPI_OFF_CODE = 8'hF0;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_ON    = 2'd1,
    CMD_OFF   = 2'd2,
    CMD_OTHER = 2'd3
  } apm_cmd_e;
endpackage

// File: rtl/apm_cmd_decode.sv
`timescale 1ns/1ps
module apm_cmd_decode
  import apm_smi_pkg::*;
#(
  parameter int unsigned       DATA_W   = 8,
  parameter logic [DATA_W-1:0] ON_CODE  = ACPI_ON_CODE,
  parameter logic [DATA_W-1:0] OFF_CODE = ACPI_OFF_CODE
) (
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output apm_cmd_e          kind
);
  always_comb begin
    if (!wr_en)                  kind = CMD_NONE;
    else if (wr_data == ON_CODE)  kind = CMD_ON;
    else if (wr_data == OFF_CODE) kind = CMD_OFF;
    else                         kind = CMD_OTHER;
  end
endmodule

// File: rtl/apm_cfg_bank.sv
`timescale 1ns/1ps
module apm_cfg_bank #(
  parameter int unsigned       ADDR_W   = 8,
  parameter int unsigned       DATA_W   = 8,
  parameter int unsigned       BASE     = 'h58,
  parameter int unsigned       COUNT    = 4,
  parameter int unsigned       GATE_IDX = 3,
  parameter int unsigned       GATE_BIT = 1,
  parameter logic [DATA_W-1:0] SAFE_VAL = 'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smm_strap,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              gate
);
  logic [DATA_W-1:0] bytes_q [COUNT];
  logic [DATA_W-1:0] rd_next;

  for (genvar i = 0; i < int'(COUNT); i++) begin : g_byte
    localparam logic [ADDR_W-1:0] SLOT    = ADDR_W'(BASE + i);
    localparam bit                IS_GATE = (i == int'(GATE_IDX));
    logic [DATA_W-1:0] rst_val;

    assign rst_val = (IS_GATE && !smm_strap) ? SAFE_VAL : '0;

    always_ff @(posedge clk) begin
      if (rst)                          bytes_q[i] <= rst_val;
      else if (wr_en && (addr == SLOT)) bytes_q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < int'(COUNT); i++) begin
      if (addr == ADDR_W'(BASE + i)) rd_next = bytes_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  assign gate = bytes_q[GATE_IDX][GATE_BIT];
endmodule

// File: rtl/apm_mode_ctrl.sv
`timescale 1ns/1ps
module apm_mode_ctrl
  import apm_smi_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  apm_cmd_e          kind,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              gate,
  output logic              sci_en,
  output logic              smi_pulse,
  output logic [DATA_W-1:0] last_val
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sci_en    <= 1'b0;
      smi_pulse <= 1'b0;
      last_val  <= '0;
    end else begin
      smi_pulse <= (kind == CMD_OTHER) && gate;
      case (kind)
        CMD_ON:  sci_en <= 1'b1;
        CMD_OFF: sci_en <= 1'b0;
        default: sci_en <= sci_en;
      endcase
      if (kind != CMD_NONE) last_val <= wr_data;
    end
  end
endmodule

// File: rtl/apm_smi_ctrl.sv
`timescale 1ns/1ps
module apm_smi_ctrl
  import apm_smi_pkg::*;
#(
  parameter int unsigned       DATA_W    = BYTE_W,
  parameter int unsigned       ADDR_W    = 8,
  parameter int unsigned       CFG_BASE  = 'h58,
  parameter int unsigned       CFG_COUNT = 4,
  parameter int unsigned       GATE_IDX  = 3,
  parameter int unsigned       GATE_BIT  = 1,
  parameter logic [DATA_W-1:0] SAFE_VAL  = 'h02,
  parameter logic [DATA_W-1:0] ON_CODE   = ACPI_ON_CODE,
  parameter logic [DATA_W-1:0] OFF_CODE  = ACPI_OFF_CODE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smm_strap,
  input  logic              ctl_wr_en,
  input  logic [DATA_W-1:0] ctl_wr_data,
  output logic [DATA_W-1:0] ctl_rd_data,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wr_data,
  output logic [DATA_W-1:0] cfg_rd_data,
  output logic              smi_pulse,
  output logic              sci_en
);
  apm_cmd_e cmd_kind;
  logic     smi_gate;

  apm_cmd_decode #(
    .DATA_W  (DATA_W),
    .ON_CODE (ON_CODE),
    .OFF_CODE(OFF_CODE)
  ) u_decode (
    .wr_en  (ctl_wr_en),
    .wr_data(ctl_wr_data),
    .kind   (cmd_kind)
  );

  apm_cfg_bank #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .BASE    (CFG_BASE),
    .COUNT   (CFG_COUNT),
    .GATE_IDX(GATE_IDX),
    .GATE_BIT(GATE_BIT),
    .SAFE_VAL(SAFE_VAL)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .smm_strap(smm_strap),
    .wr_en    (cfg_wr_en),
    .addr     (cfg_addr),
    .wr_data  (cfg_wr_data),
    .rd_data  (cfg_rd_data),
    .gate     (smi_gate)
  );

  apm_mode_ctrl #(
    .DATA_W(DATA_W)
  ) u_mode (
    .clk      (clk),
    .rst      (rst),
    .kind     (cmd_kind),
    .wr_data  (ctl_wr_data),
    .gate     (smi_gate),
    .sci_en   (sci_en),
    .smi_pulse(smi_pulse),
    .last_val (ctl_rd_data)
  );
endmodule

// File: rtl/apm_smi_ctrl_chk.sv
`timescale 1ns/1ps
module apm_smi_ctrl_chk #(
  parameter int unsigned       DATA_W   = 8,
  parameter logic [DATA_W-1:0] ON_CODE  = 8'hF1,
  parameter logic [DATA_W-1:0] OFF_CODE = 8'hF0
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_wr_en,
  input logic [DATA_W-1:0] ctl_wr_data,
  input logic [DATA_W-1:0] ctl_rd_data,
  input logic              smi_pulse,
  input logic              sci_en,
  input logic              smi_gate
);
  logic is_cmd;
  assign is_cmd = ctl_wr_en && ((ctl_wr_data == ON_CODE) || (ctl_wr_data == OFF_CODE));

  p_sci_set_r3: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr_en && ctl_wr_data == ON_CODE) |=> sci_en);

  p_sci_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr_en && ctl_wr_data == OFF_CODE) |=> !sci_en);

  p_cmd_no_smi_r5: assert property (@(posedge clk) disable iff (rst)
    is_cmd |=> !smi_pulse);

  p_gate_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr_en && !is_cmd && !smi_gate) |=> !smi_pulse);

  p_gate_passes_r8: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr_en && !is_cmd && smi_gate) |=> smi_pulse);

  p_pulse_needs_write_r7: assert property (@(posedge clk) disable iff (rst)
    (!ctl_wr_en) |=> !smi_pulse);

  p_sci_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!is_cmd) |=> $stable(sci_en));

  p_readback_r10: assert property (@(posedge clk) disable iff (rst)
    ctl_wr_en |=> (ctl_rd_data == $past(ctl_wr_data)));
endmodule

bind apm_smi_ctrl apm_smi_ctrl_chk #(
  .DATA_W  (DATA_W),
  .ON_CODE (ON_CODE),
  .OFF_CODE(OFF_CODE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ctl_wr_en  (ctl_wr_en),
  .ctl_wr_data(ctl_wr_data),
  .ctl_rd_data(ctl_rd_data),
  .smi_pulse  (smi_pulse),
  .sci_en     (sci_en),
  .smi_gate   (smi_gate)
);

// File: tb/apm_smi_ctrl_tb.sv
`timescale 1ns/1ps
module apm_smi_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smm_strap = 1'b1;
  logic       ctl_wr_en = 1'b0;
  logic [7:0] ctl_wr_data = '0;
  logic [7:0] ctl_rd_data;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [7:0] cfg_wr_data = '0;
  logic [7:0] cfg_rd_data;
  logic       smi_pulse;
  logic       sci_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  apm_smi_ctrl u_dut (
    .clk(clk), .rst(rst), .smm_strap(smm_strap),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
    .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .smi_pulse(smi_pulse), .sci_en(sci_en)
  );

  typedef struct {
    logic       smi;
    logic       sci;
    logic [7:0] ctl;
    logic [7:0] cfg;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;

  // reference state
  logic [7:0] m_cfg [4];
  logic       m_sci;
  logic [7:0] m_ctl;

  task automatic model_reset(input logic strap);
    for (int i = 0; i < 4; i++) m_cfg[i] = 8'h00;
    if (!strap) m_cfg[3] = 8'h02;
    m_sci = 1'b0;
    m_ctl = 8'h00;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst = 1'b1; smm_strap = strap;
    ctl_wr_en = 1'b0; cfg_wr_en = 1'b0; cfg_addr = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset(strap);
  endtask

  // driver: one cycle of stimulus, expected outputs pushed for the following edge
  task automatic step(input logic ce, input logic [7:0] cd,
                      input logic fe, input logic [7:0] fa, input logic [7:0] fd,
                      input string tag);
    exp_t e;
    @(negedge clk);
    ctl_wr_en = ce; ctl_wr_data = cd;
    cfg_wr_en = fe; cfg_addr = fa; cfg_wr_data = fd;
    e.smi = ce && (cd != 8'hF1) && (cd != 8'hF0) && m_cfg[3][1];
    if (ce && cd == 8'hF1) m_sci = 1'b1;
    if (ce && cd == 8'hF0) m_sci = 1'b0;
    if (ce) m_ctl = cd;
    e.sci = m_sci;
    e.ctl = m_ctl;
    e.cfg = (fa >= 8'h58 && fa <= 8'h5B) ? m_cfg[fa - 8'h58] : 8'h00;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (fe && fa >= 8'h58 && fa <= 8'h5B) m_cfg[fa - 8'h58] = fd;
  endtask

  task automatic idle(input logic [7:0] fa, input string tag);
    step(1'b0, 8'h00, 1'b0, fa, 8'h00, tag);
  endtask

  task automatic cmp8(input string tag, input string what,
                      input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, expv);
    end
  endtask

  // monitor: pops one expected item per cycle, after the edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        cmp8(t, "smi_pulse", {7'd0, smi_pulse}, {7'd0, e.smi});
        cmp8(t, "sci_en", {7'd0, sci_en}, {7'd0, e.sci});
        cmp8(t, "ctl_rd_data", ctl_rd_data, e.ctl);
        cmp8(t, "cfg_rd_data", cfg_rd_data, e.cfg);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);
    // R1: reset state with SMM supported
    for (int a = 8'h58; a <= 8'h5B; a++) idle(8'(a), "R1");
    // R6: gate clear, ordinary code gives no SMI; R10 readback; R9 sci unchanged
    step(1'b1, 8'h55, 1'b0, 8'h5B, 8'h00, "R6");
    idle(8'h5B, "R10");
    step(1'b1, 8'hF1, 1'b0, 8'h5B, 8'h00, "R3");
    idle(8'h5B, "R3");
    // open the gate, keep sci through a cfg write (R9)
    step(1'b0, 8'h00, 1'b1, 8'h5B, 8'h02, "R9");
    step(1'b1, 8'h33, 1'b0, 8'h5B, 8'h00, "R6");
    idle(8'h5B, "R7");
    step(1'b1, 8'hF0, 1'b0, 8'h5B, 8'h00, "R4");
    step(1'b1, 8'hF1, 1'b0, 8'h5B, 8'h00, "R5");
    step(1'b1, 8'hF0, 1'b0, 8'h5B, 8'h00, "R5");
    // R7: back-to-back pulses
    step(1'b1, 8'h10, 1'b0, 8'h5B, 8'h00, "R7");
    step(1'b1, 8'h11, 1'b0, 8'h5B, 8'h00, "R7");
    step(1'b1, 8'h12, 1'b0, 8'h5B, 8'h00, "R7");
    idle(8'h5B, "R7");
    // R8: gate closes in the same cycle; old (open) value decides
    step(1'b1, 8'h44, 1'b1, 8'h5B, 8'hFD, "R8");
    // R11: only bit 1 gates
    step(1'b1, 8'h45, 1'b0, 8'h5B, 8'h00, "R11");
    idle(8'h5B, "R11");
    // R8: gate opens in the same cycle; old (closed) value decides
    step(1'b1, 8'h46, 1'b1, 8'h5B, 8'h02, "R8");
    step(1'b1, 8'h47, 1'b0, 8'h5B, 8'h00, "R8");
    // R11: other window bytes and out-of-window addresses
    step(1'b0, 8'h00, 1'b1, 8'h58, 8'hA1, "R11");
    step(1'b0, 8'h00, 1'b1, 8'h59, 8'hB2, "R11");
    step(1'b0, 8'h00, 1'b1, 8'h5A, 8'hC3, "R11");
    step(1'b0, 8'h00, 1'b1, 8'h57, 8'h99, "R11");
    step(1'b0, 8'h00, 1'b1, 8'h5C, 8'h88, "R11");
    for (int a = 8'h56; a <= 8'h5D; a++) idle(8'(a), "R11");
    // R9: ordinary writes keep sci_en
    step(1'b1, 8'hF1, 1'b0, 8'h5B, 8'h00, "R9");
    step(1'b1, 8'h00, 1'b0, 8'h5B, 8'h00, "R9");
    step(1'b1, 8'hFF, 1'b0, 8'h5B, 8'h00, "R9");
    idle(8'h5B, "R10");
    // R2: reset without SMM support
    do_reset(1'b0);
    for (int a = 8'h58; a <= 8'h5B; a++) idle(8'(a), "R2");
    step(1'b1, 8'h77, 1'b0, 8'h5B, 8'h00, "R2");
    idle(8'h5B, "R2");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule